// File: doc/BRIEF.md
# Software-Loaded Translation Buffer with Lock Bits

This block keeps a set of address translations that software places and manages. It has 64 entries, and each entry holds a 64-bit tag and a 64-bit translation word. In the translation word, one bit marks the entry as valid and another marks it as locked against replacement. Software first loads the tag into a tag-staging register through a small indexed register port. It then issues a fill write. The fill places that tag, together with the translation word on the write bus, into an entry that the hardware picks.

The hardware picks the fill entry with a fixed search. It takes the lowest-numbered empty entry. When no entry is empty, it takes the lowest-numbered entry that is not locked. When every entry is both valid and locked, the fill is dropped. A direct write skips the search and names the entry through an address field. A probe port compares a key against every valid tag and returns the lowest-numbered match. A peek port reads back any entry by its index. A flush input empties the whole buffer in one cycle.

All outputs are registered. Every write completes in the clock cycle in which it is issued.

Top module: `swtlb_top`

## Requirements
- R1: After a synchronous reset, every entry is invalid, the tag-staging register holds zero, `probe_hit_o` is 0 and `probe_tag_o` is zero.
- R2: A register write with `reg_sel_i` equal to 6 loads `wdata_i` into the tag-staging register. A register write with any other select value leaves the tag-staging register unchanged.
- R3: A fill write stores the tag-staging register as the tag and `wdata_i` as the translation word. It uses the lowest-index entry whose valid bit is clear. The new valid bit is `wdata_i[63]` and the new lock bit is `wdata_i[6]`.
- R4: When every entry is valid, a fill write replaces the lowest-index entry whose lock bit (bit 6) is clear.
- R5: When every entry is valid and locked, a fill write changes no entry.
- R6: A direct write stores the tag-staging register and `wdata_i` into the entry numbered `direct_addr_i[8:3]`, whatever that entry's valid and lock state. Bit 63 of the data may leave the entry invalid.
- R7: One cycle after a key is presented, `probe_hit_o`, `probe_idx_o` and `probe_tag_o` give the lowest-index valid entry whose tag equals the key exactly. When no valid entry matches, `probe_hit_o` is 0 and `probe_tag_o` is zero.
- R8: A flush clears every valid bit in one cycle. Flushed entries never match a probe.
- R9: One cycle after an index is presented, `peek_tag_o` and `peek_tte_o` give that entry's tag and translation word. Bit 63 of `peek_tte_o` shows the entry's current valid state.
- R10: When strobes coincide, only one operation is taken, in the priority order flush, fill, direct write, register write. The others are dropped.
- R11: A probe or peek sampled in the same cycle as a write sees the contents as they were before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_i | input | 1 | Invalidate all entries |
| fill_wr_i | input | 1 | Fill write using the replacement search |
| direct_wr_i | input | 1 | Write to an explicit entry |
| direct_addr_i | input | 9 | Address for a direct write; bits 8:3 name the entry |
| reg_wr_i | input | 1 | Register-port write strobe |
| reg_sel_i | input | 4 | Register select; 6 is the tag-staging register |
| wdata_i | input | 64 | Write data for the translation word or the register |
| probe_tag_i | input | 64 | Probe key |
| probe_hit_o | output | 1 | Probe found a valid match |
| probe_idx_o | output | 6 | Index of the matching entry |
| probe_tag_o | output | 64 | Tag of the matching entry, or zero |
| peek_idx_i | input | 6 | Entry to read back |
| peek_tag_o | output | 64 | Tag of the entry read back |
| peek_tte_o | output | 64 | Translation word of the entry read back, with its live valid bit |

## Verification
The hardest state to reach from the ports is a buffer in which all 64 entries are valid and locked. Random fills seldom get there, because about one in four writes is invalid and most are unlocked. A directed sequence therefore loads 64 distinct tags with locked, valid words. It then checks that one further fill is dropped. It next unlocks a single middle entry with a direct write and checks that the following fill lands exactly there. Random traffic over a small pool of tags then produces duplicate matches, so the lowest-index rule is exercised as well.

// File: rtl/swtlb_pkg.sv
package swtlb_pkg;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_FLUSH,
    OP_FILL,
    OP_DIRECT,
    OP_TAGREG
  } swtlb_op_e;

  // one operation per cycle: flush > fill > direct > register
  function automatic swtlb_op_e pick_op(input logic flush, input logic fill,
                                        input logic direct, input logic regw);
    if (flush)       return OP_FLUSH;
    else if (fill)   return OP_FILL;
    else if (direct) return OP_DIRECT;
    else if (regw)   return OP_TAGREG;
    else             return OP_NONE;
  endfunction

endpackage

// File: rtl/swtlb_pick.sv
module swtlb_pick #(
  parameter int N  = 64,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  // lowest set bit wins
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/swtlb_store.sv
module swtlb_store #(
  parameter int ENTRIES   = 64,
  parameter int DW        = 64,
  parameter int VALID_POS = 63,
  parameter int LOCK_POS  = 6,
  parameter int IW        = $clog2(ENTRIES)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  flush_i,
  input  logic                  we_i,
  input  logic [IW-1:0]         widx_i,
  input  logic [DW-1:0]         wtag_i,
  input  logic [DW-1:0]         wtte_i,
  input  logic [IW-1:0]         ridx_i,
  output logic [ENTRIES-1:0]    valid_o,
  output logic [ENTRIES-1:0]    lock_o,
  output logic [ENTRIES*DW-1:0] tags_o,
  output logic [DW-1:0]         rtag_o,
  output logic [DW-1:0]         rtte_o
);
  logic [ENTRIES-1:0]    valid_q;
  logic [ENTRIES-1:0]    lock_q;
  logic [ENTRIES*DW-1:0] tag_q;
  logic [DW-1:0]         tte_mem [ENTRIES];
  logic [DW-1:0]         rtte_q;
  logic [DW-1:0]         rtag_q;
  logic                  rvalid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      lock_q  <= '0;
    end else if (flush_i) begin
      valid_q <= '0;
    end else if (we_i) begin
      valid_q[widx_i] <= wtte_i[VALID_POS];
      lock_q[widx_i]  <= wtte_i[LOCK_POS];
    end
  end

  // tags must stay in flops: every tag feeds the parallel compare
  always_ff @(posedge clk) begin
    if (we_i && !flush_i) tag_q[widx_i*DW +: DW] <= wtag_i;
  end

  // translation words: one write port, one registered read port
  always_ff @(posedge clk) begin
    if (we_i && !flush_i) tte_mem[widx_i] <= wtte_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rtte_q   <= '0;
      rtag_q   <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rtte_q   <= tte_mem[ridx_i];
      rtag_q   <= tag_q[ridx_i*DW +: DW];
      rvalid_q <= valid_q[ridx_i];
    end
  end

  always_comb begin
    rtte_o            = rtte_q;
    rtte_o[VALID_POS] = rvalid_q;
  end

  assign rtag_o  = rtag_q;
  assign valid_o = valid_q;
  assign lock_o  = lock_q;
  assign tags_o  = tag_q;

  // R8
  flush_clear_chk: assert property (@(posedge clk) disable iff (rst)
    flush_i |=> (valid_q == '0));

  // R3
  write_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (we_i && !flush_i) |=> (valid_q[$past(widx_i)] == $past(wtte_i[VALID_POS])));
endmodule

// File: rtl/swtlb_match.sv
module swtlb_match #(
  parameter int ENTRIES = 64,
  parameter int DW      = 64,
  parameter int IW      = $clog2(ENTRIES)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [DW-1:0]         key_i,
  input  logic [ENTRIES-1:0]    valid_i,
  input  logic [ENTRIES*DW-1:0] tags_i,
  output logic                  hit_o,
  output logic [IW-1:0]         idx_o,
  output logic [DW-1:0]         tag_o
);
  logic [ENTRIES-1:0] hit_vec;
  logic               any_hit;
  logic [IW-1:0]      first_idx;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = valid_i[g] && (tags_i[g*DW +: DW] == key_i);
  end

  swtlb_pick #(.N(ENTRIES), .IW(IW)) u_first (
    .req_i  (hit_vec),
    .found_o(any_hit),
    .idx_o  (first_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_o <= 1'b0;
      idx_o <= '0;
      tag_o <= '0;
    end else begin
      hit_o <= any_hit;
      idx_o <= any_hit ? first_idx : '0;
      tag_o <= any_hit ? tags_i[first_idx*DW +: DW] : '0;
    end
  end

  // R7
  miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !hit_o |-> (tag_o == '0));

  // R7
  hit_key_chk: assert property (@(posedge clk) disable iff (rst)
    hit_o |-> (tag_o == $past(key_i)));
endmodule

// File: rtl/swtlb_top.sv
module swtlb_top #(
  parameter int ENTRIES    = 64,
  parameter int DW         = 64,
  parameter int VALID_POS  = 63,
  parameter int LOCK_POS   = 6,
  parameter int NREGS      = 16,
  parameter int TAGREG_SEL = 6,
  localparam int IW        = $clog2(ENTRIES),
  localparam int RW        = $clog2(NREGS),
  localparam int AW        = IW + 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush_i,
  input  logic          fill_wr_i,
  input  logic          direct_wr_i,
  input  logic [AW-1:0] direct_addr_i,
  input  logic          reg_wr_i,
  input  logic [RW-1:0] reg_sel_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] probe_tag_i,
  output logic          probe_hit_o,
  output logic [IW-1:0] probe_idx_o,
  output logic [DW-1:0] probe_tag_o,
  input  logic [IW-1:0] peek_idx_i,
  output logic [DW-1:0] peek_tag_o,
  output logic [DW-1:0] peek_tte_o
);
  import swtlb_pkg::*;

  swtlb_op_e             op;
  logic [DW-1:0]         tagacc_q;
  logic [ENTRIES-1:0]    valid_vec;
  logic [ENTRIES-1:0]    lock_vec;
  logic [ENTRIES*DW-1:0] tags_flat;
  logic                  free_found, unl_found;
  logic [IW-1:0]         free_idx, unl_idx;
  logic [IW-1:0]         direct_idx;
  logic                  fill_ok;
  logic                  we;
  logic [IW-1:0]         widx;
  logic                  unused_addr_bits;

  assign op               = pick_op(flush_i, fill_wr_i, direct_wr_i, reg_wr_i);
  assign direct_idx       = direct_addr_i[AW-1:3];
  assign unused_addr_bits = ^direct_addr_i[2:0];

  always_ff @(posedge clk) begin
    if (rst) tagacc_q <= '0;
    else if (op == OP_TAGREG && reg_sel_i == RW'(TAGREG_SEL)) tagacc_q <= wdata_i;
  end

  swtlb_pick #(.N(ENTRIES), .IW(IW)) u_free (
    .req_i  (~valid_vec),
    .found_o(free_found),
    .idx_o  (free_idx)
  );

  swtlb_pick #(.N(ENTRIES), .IW(IW)) u_unlocked (
    .req_i  (~lock_vec),
    .found_o(unl_found),
    .idx_o  (unl_idx)
  );

  assign fill_ok = free_found || unl_found;
  assign we      = (op == OP_FILL && fill_ok) || (op == OP_DIRECT);
  assign widx    = (op == OP_FILL) ? (free_found ? free_idx : unl_idx) : direct_idx;

  swtlb_store #(
    .ENTRIES(ENTRIES), .DW(DW), .VALID_POS(VALID_POS), .LOCK_POS(LOCK_POS), .IW(IW)
  ) u_store (
    .clk    (clk),
    .rst    (rst),
    .flush_i(op == OP_FLUSH),
    .we_i   (we),
    .widx_i (widx),
    .wtag_i (tagacc_q),
    .wtte_i (wdata_i),
    .ridx_i (peek_idx_i),
    .valid_o(valid_vec),
    .lock_o (lock_vec),
    .tags_o (tags_flat),
    .rtag_o (peek_tag_o),
    .rtte_o (peek_tte_o)
  );

  swtlb_match #(.ENTRIES(ENTRIES), .DW(DW), .IW(IW)) u_match (
    .clk    (clk),
    .rst    (rst),
    .key_i  (probe_tag_i),
    .valid_i(valid_vec),
    .tags_i (tags_flat),
    .hit_o  (probe_hit_o),
    .idx_o  (probe_idx_o),
    .tag_o  (probe_tag_o)
  );

  // R5
  locked_full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_FILL && (&valid_vec) && (&lock_vec)) |=>
      ($stable(valid_vec) && $stable(lock_vec)));

  // R4
  unlocked_victim_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_FILL && (&valid_vec) && unl_found) |=>
      (lock_vec[$past(unl_idx)] == $past(wdata_i[LOCK_POS])));

  // R6
  direct_place_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_DIRECT) |=> (valid_vec[$past(direct_idx)] == $past(wdata_i[VALID_POS])));

  // R2
  tagreg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_TAGREG && reg_sel_i != RW'(TAGREG_SEL)) |=> $stable(tagacc_q));

  // R10
  flush_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (flush_i && fill_wr_i) |=> (valid_vec == '0));
endmodule

// File: tb/swtlb_top_tb.sv
`timescale 1ns/1ps
module swtlb_top_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        flush_i, fill_wr_i, direct_wr_i, reg_wr_i;
  logic [8:0]  direct_addr_i;
  logic [3:0]  reg_sel_i;
  logic [63:0] wdata_i, probe_tag_i;
  logic        probe_hit_o;
  logic [5:0]  probe_idx_o, peek_idx_i;
  logic [63:0] probe_tag_o, peek_tag_o, peek_tte_o;

  always #10 clk = ~clk;

  swtlb_top dut_i (
    .clk(clk), .rst(rst), .flush_i(flush_i), .fill_wr_i(fill_wr_i),
    .direct_wr_i(direct_wr_i), .direct_addr_i(direct_addr_i), .reg_wr_i(reg_wr_i),
    .reg_sel_i(reg_sel_i), .wdata_i(wdata_i), .probe_tag_i(probe_tag_i),
    .probe_hit_o(probe_hit_o), .probe_idx_o(probe_idx_o), .probe_tag_o(probe_tag_o),
    .peek_idx_i(peek_idx_i), .peek_tag_o(peek_tag_o), .peek_tte_o(peek_tte_o)
  );

  // reference model
  logic [63:0] m_tag [64];
  logic [63:0] m_tte [64];
  bit          m_valid [64];
  bit          m_lock [64];
  bit          m_written [64];
  logic [63:0] m_ta;
  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  function automatic logic [63:0] poolv(input int i);
    return 64'hC3A0_0000_0000_0000 + 64'(i) * 64'h0000_0100_0000_2000;
  endfunction

  function automatic void model_apply(input bit fl, input bit fi, input bit di,
      input logic [8:0] a, input bit rw, input logic [3:0] sel, input logic [63:0] d);
    int v;
    v = -1;
    if (fl) begin
      for (int i = 0; i < 64; i++) m_valid[i] = 0;
    end else if (fi || di) begin
      if (di && !fi) v = int'(a[8:3]);
      else begin
        for (int i = 63; i >= 0; i--) if (!m_valid[i]) v = i;
        if (v < 0) for (int i = 63; i >= 0; i--) if (!m_lock[i]) v = i;
      end
      if (v >= 0) begin
        m_tag[v] = m_ta; m_tte[v] = d; m_valid[v] = d[63];
        m_lock[v] = d[6]; m_written[v] = 1;
      end
    end else if (rw && sel == 4'd6) m_ta = d;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op(input bit fl, input bit fi, input bit di, input logic [8:0] a,
                    input bit rw, input logic [3:0] sel, input logic [63:0] d);
    flush_i = fl; fill_wr_i = fi; direct_wr_i = di; direct_addr_i = a;
    reg_wr_i = rw; reg_sel_i = sel; wdata_i = d;
    @(negedge clk);
    model_apply(fl, fi, di, a, rw, sel, d);
    flush_i = 0; fill_wr_i = 0; direct_wr_i = 0; reg_wr_i = 0;
  endtask

  task automatic set_ta(input logic [63:0] t);
    op(0, 0, 0, 9'd0, 1, 4'd6, t);
  endtask

  // probe and peek in one cycle, compared against the model
  task automatic look(input logic [63:0] key, input logic [5:0] idx, input string req);
    bit eh; int ei; logic [63:0] et;
    probe_tag_i = key; peek_idx_i = idx;
    @(negedge clk);
    eh = 0; ei = 0; et = '0;
    for (int i = 63; i >= 0; i--)
      if (m_valid[i] && m_tag[i] == key) begin eh = 1; ei = i; et = m_tag[i]; end
    check(probe_hit_o == eh && probe_tag_o == et && (!eh || probe_idx_o == 6'(ei)),
          req, {probe_hit_o, 57'd0, probe_idx_o}, {eh, 57'd0, 6'(ei)});
    check(peek_tte_o[63] == m_valid[idx], {req, " R9 valid"}, peek_tte_o, {m_valid[idx], 63'd0});
    if (m_written[idx]) begin
      check(peek_tag_o == m_tag[idx], {req, " R9 tag"}, peek_tag_o, m_tag[idx]);
      check(peek_tte_o[62:0] == m_tte[idx][62:0], {req, " R9 tte"}, peek_tte_o, m_tte[idx]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    void'($urandom(32'd4242));
    for (int i = 0; i < 64; i++) begin
      m_valid[i] = 0; m_lock[i] = 0; m_written[i] = 0; m_tag[i] = '0; m_tte[i] = '0;
    end
    m_ta = '0;
    rst = 1; flush_i = 0; fill_wr_i = 0; direct_wr_i = 0; reg_wr_i = 0;
    direct_addr_i = '0; reg_sel_i = '0; wdata_i = '0; probe_tag_i = '0; peek_idx_i = '0;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1: empty after reset, staging register zero
    look(64'd0, 6'd0, "R1 reset");
    check(probe_hit_o == 0 && probe_tag_o == 0, "R1 outputs", probe_tag_o, 64'd0);
    op(0, 1, 0, 9'd0, 0, 4'd0, 64'h8000_0000_0000_1000);
    look(64'd0, 6'd0, "R1 staging zero");
    check(peek_tag_o == 64'd0, "R1 staging tag", peek_tag_o, 64'd0);

    // R2: only select 6 loads the staging register
    set_ta(poolv(1));
    op(0, 0, 0, 9'd0, 1, 4'd3, poolv(2));
    op(0, 1, 0, 9'd0, 0, 4'd0, 64'h8000_0000_0000_2000);
    look(poolv(1), 6'd1, "R2 R3 fill tag");
    check(peek_tag_o == poolv(1), "R2 select 3 ignored", peek_tag_o, poolv(1));

    // R6 then R3: invalidate entry 0 directly, next fill must reuse it
    op(0, 0, 1, {6'd0, 3'b101}, 0, 4'd0, 64'h0000_0000_0000_0040);
    look(64'd0, 6'd0, "R6 direct invalidate");
    set_ta(poolv(3));
    op(0, 1, 0, 9'd0, 0, 4'd0, 64'h8000_0000_0000_3000);
    look(poolv(3), 6'd0, "R3 lowest invalid");

    // R8: flush
    op(1, 0, 0, 9'd0, 0, 4'd0, 64'd0);
    look(poolv(3), 6'd0, "R8 flush");

    // R5: all valid and locked
    for (int i = 0; i < 64; i++) begin
      set_ta(64'h7700_0000_0000_0000 + 64'(i));
      op(0, 1, 0, 9'd0, 0, 4'd0, 64'h8000_0000_0001_0040 + 64'(i << 12));
    end
    set_ta(poolv(5));
    op(0, 1, 0, 9'd0, 0, 4'd0, 64'h8000_0000_0000_5040);
    look(poolv(5), 6'd63, "R5 dropped");
    look(64'h7700_0000_0000_0000, 6'd0, "R5 entry 0 kept");

    // R4: unlock entry 37 by direct write, next fill lands there
    op(0, 0, 1, {6'd37, 3'b000}, 0, 4'd0, 64'h8000_0000_0000_7000);
    set_ta(poolv(6));
    op(0, 1, 0, 9'd0, 0, 4'd0, 64'h8000_0000_0000_6040);
    look(poolv(6), 6'd37, "R4 first unlocked");
    check(probe_idx_o == 6'd37, "R4 index", {58'd0, probe_idx_o}, 64'd37);

    // R7: duplicate tags, lowest index wins
    set_ta(poolv(7));
    op(0, 0, 1, {6'd50, 3'b000}, 0, 4'd0, 64'h8000_0000_0000_8000);
    op(0, 0, 1, {6'd20, 3'b000}, 0, 4'd0, 64'h8000_0000_0000_9000);
    look(poolv(7), 6'd50, "R7 lowest match");
    check(probe_idx_o == 6'd20, "R7 index", {58'd0, probe_idx_o}, 64'd20);

    // R10: flush beats fill; fill beats register write
    set_ta(poolv(0));
    op(1, 1, 0, 9'd0, 0, 4'd0, 64'h8000_0000_0000_A000);
    look(poolv(0), 6'd0, "R10 flush over fill");
    op(0, 1, 0, 9'd0, 1, 4'd6, poolv(4));
    look(poolv(0), 6'd0, "R10 fill over register");

    // R11: probe in the write cycle sees the old contents
    set_ta(poolv(2));
    probe_tag_i = poolv(2);
    op(0, 1, 0, 9'd0, 0, 4'd0, 64'h8000_0000_0000_B000);
    check(probe_hit_o == 0, "R11 same cycle", {63'd0, probe_hit_o}, 64'd0);
    @(negedge clk);
    check(probe_hit_o == 1 && probe_idx_o == 6'd1, "R11 next cycle",
          {63'd0, probe_hit_o}, 64'd1);

    // constrained random traffic
    for (int n = 0; n < 2500; n++) begin
      int k;
      k = int'($urandom % 16);
      d = {$urandom, $urandom};
      d[63] = ($urandom % 4) != 0;
      d[6]  = ($urandom % 3) == 0;
      if (k == 0 && ($urandom % 4) == 0) op(1, 0, 0, 9'd0, 0, 4'd0, d);
      else if (k < 4) op(0, 0, 0, 9'd0, 1, 4'(($urandom % 2) ? 6 : $urandom % 16),
                         poolv(int'($urandom % 8)));
      else if (k < 10) op(0, 1, 0, 9'd0, ($urandom % 4) == 0, 4'd6, d);
      else if (k < 14) op(0, 0, 1, 9'($urandom), 0, 4'd0, d);
      else op(0, ($urandom % 2) == 0, 1, 9'($urandom), 1, 4'd6, d);
      look(($urandom % 8) != 0 ? poolv(int'($urandom % 8)) : {$urandom, $urandom},
           6'($urandom), "R3 R4 R6 R7 R9 random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule